// File: doc/BRIEF.md
# Gated Branch Clock with Shared PLL Voting

This block passes a source clock onto a peripheral through a glitch-free gate and reports whether that clock is really running. Software sets an enable bit in a branch control register. The enable crosses into the source clock domain, and the gated clock starts at the next clean low phase. A read-only "off" flag in the same register stays set until the gated clock has produced edges, so driver code can set the enable and then poll the flag. Clearing the enable parks the output low, and the flag comes back once the stop has been seen from the register side.

The block also holds the voting logic for a shared PLL. Each bit of a vote register belongs to one requester. The PLL request output is the OR of all those bits. The PLL's lock input is synchronised and qualified by a fixed number of reference cycles, and the result appears as an active bit in a read-only status register. A driver that finds the active bit already set does not need to vote. Otherwise it sets its vote bit and waits for the active bit. A second vote register carries a single request bit for the peripheral bus clock branch, and this bit is brought out as a pin.

Registers are accessed over a simple single-cycle bus with word addresses: 0 is branch control, 1 is PLL vote, 2 is bus vote, 3 is PLL status. Read data is combinational from the address.

Top module: `cbg_branch_top`

## Requirements
- R1: After reset, every register field reads 0 except the off flag (branch control bit 31), which reads 1. `gclk_o`, `pll_req_o` and `bus_branch_req_o` are all low.
- R2: Branch control bit 0 is the stored enable and reads back as written. Writes to bits 1 to 31 have no effect, and those bits other than bit 31 read 0.
- R3: After the enable is set, bit 31 keeps reading 1 until `gclk_o` has produced at least one rising edge, and it reads 0 within 40 register clock cycles.
- R4: `gclk_o` is never high while `src_clk` is low, and while the branch is enabled it toggles with `src_clk`.
- R5: After the enable is cleared, `gclk_o` stops low, shows no further edges, and bit 31 reads 1 again within 20 register clock cycles.
- R6: PLL vote bits [NUM_VOTERS-1:0] (bits [3:0] by default) are stored and read back, upper bits read 0, and `pll_req_o` is 1 exactly when any stored vote bit is 1, from the cycle after the write.
- R7: Status bit 17 reads 1 only once `pll_lock_i` has been high for LOCK_CYCLES register cycles while `pll_req_o` is high. It is 1 no later than LOCK_CYCLES+4 cycles after lock rises. It returns to 0 within 4 cycles after lock falls, and it stays 0 while no vote is set.
- R8: Bus vote bit 10 is stored, drives `bus_branch_req_o` from the cycle after the write, and is the only bit of that register that reads non-zero.
- R9: The PLL status register is read-only, and a write to it leaves bit 17 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock, also the PLL lock reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| src_clk | input | 1 | Root clock to be gated |
| gclk_o | output | 1 | Gated branch clock |
| pll_req_o | output | 1 | OR of all PLL vote bits |
| pll_lock_i | input | 1 | Lock indication from the PLL |
| bus_branch_req_o | output | 1 | Request for the peripheral bus clock branch |

## Verification
On every cycle the assertions check the register-side bookkeeping. Each write to a control or vote register must show up on the stored enable or on the request pins one cycle later. The qualified PLL active bit may never be set unless the synchronised lock was high in the cycle before. In the source domain, the gate's run flag must follow the synchronised enable delayed by one edge. The cross-domain behaviour can only be shown by the bench scenarios: the order between the first gated edge and the off flag clearing, the clean stop at a low phase, the lock qualification window, and the fact that writes to read-only fields have no effect.

// File: rtl/cbg_pkg.sv
package cbg_pkg;
  localparam int REG_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 2'd0,
    RA_PVOTE  = 2'd1,
    RA_BVOTE  = 2'd2,
    RA_PSTAT  = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_OFF_BIT  = 31;
  localparam int BVOTE_BIT     = 10;
  localparam int PSTAT_ACT_BIT = 17;
endpackage

// File: rtl/cbg_sync.sv
module cbg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cbg_gate.sv
module cbg_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic src_clk,
  input  logic rst_n,
  input  logic en_i,
  output logic gclk_o,
  output logic run_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_src_n;
  logic       en_sync;
  logic       en_lat;
  logic       run_q;

  // reset: asserts at once, releases on a source clock edge
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_src_n = rst_pipe_q[1];

  cbg_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk  (src_clk),
    .rst_n(rst_src_n),
    .d_i  (en_i),
    .q_o  (en_sync)
  );

  // transparent only while the source is low: the gate opens or closes in a low phase
  always_latch begin
    if (!rst_src_n)    en_lat = 1'b0;
    else if (!src_clk) en_lat = en_sync;
  end

  assign gclk_o = src_clk & en_lat;

  // set on a rising edge that the gate passed
  always_ff @(posedge src_clk or negedge rst_src_n) begin
    if (!rst_src_n) run_q <= 1'b0;
    else            run_q <= en_lat;
  end
  assign run_o = run_q;

  a_r4_run_follows_enable: assert property (
    @(posedge src_clk) disable iff (!rst_src_n) run_q == $past(en_sync));
endmodule

// File: rtl/cbg_pll_vote.sv
module cbg_pll_vote #(
  parameter int LOCK_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic lock_i,
  output logic active_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);

  logic          lock_s;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  cbg_sync #(.STAGES(2)) u_lock_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (lock_i),
    .q_o  (lock_s)
  );

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (!(req_i && lock_s)) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else if (cnt_q == CW'(LOCK_CYCLES - 1)) begin
      act_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active_o = act_q;

  a_r7_active_needs_lock: assert property (
    @(posedge clk) disable iff (!rst_n) act_q |-> $past(lock_s));
endmodule

// File: rtl/cbg_branch_top.sv
module cbg_branch_top
  import cbg_pkg::*;
#(
  parameter int NUM_VOTERS  = 4,
  parameter int LOCK_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              src_clk,
  output logic              gclk_o,
  output logic              pll_req_o,
  input  logic              pll_lock_i,
  output logic              bus_branch_req_o
);
  logic                  wr_ctrl, wr_pvote, wr_bvote;
  logic                  en_q, en_d;
  logic [NUM_VOTERS-1:0] votes_q, votes_d;
  logic                  bvote_q, bvote_d;
  logic                  run_src, run_reg;
  logic                  pll_active;
  logic                  unused_wbits;

  assign unused_wbits = ^bus_wdata;

  assign wr_ctrl  = bus_sel && bus_we && (bus_addr == RA_CTRL);
  assign wr_pvote = bus_sel && bus_we && (bus_addr == RA_PVOTE);
  assign wr_bvote = bus_sel && bus_we && (bus_addr == RA_BVOTE);

  always_comb begin
    en_d    = en_q;
    votes_d = votes_q;
    bvote_d = bvote_q;
    if (wr_ctrl)  en_d    = bus_wdata[CTRL_EN_BIT];
    if (wr_pvote) votes_d = bus_wdata[NUM_VOTERS-1:0];
    if (wr_bvote) bvote_d = bus_wdata[BVOTE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      votes_q <= '0;
      bvote_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      votes_q <= votes_d;
      bvote_q <= bvote_d;
    end
  end

  cbg_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .src_clk(src_clk),
    .rst_n  (rst_n),
    .en_i   (en_q),
    .gclk_o (gclk_o),
    .run_o  (run_src)
  );

  cbg_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (run_src),
    .q_o  (run_reg)
  );

  assign pll_req_o        = |votes_q;
  assign bus_branch_req_o = bvote_q;

  cbg_pll_vote #(.LOCK_CYCLES(LOCK_CYCLES)) u_pll (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (pll_req_o),
    .lock_i  (pll_lock_i),
    .active_o(pll_active)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      RA_CTRL: begin
        bus_rdata[CTRL_EN_BIT]  = en_q;
        bus_rdata[CTRL_OFF_BIT] = ~run_reg;
      end
      RA_PVOTE: bus_rdata[NUM_VOTERS-1:0]  = votes_q;
      RA_BVOTE: bus_rdata[BVOTE_BIT]       = bvote_q;
      RA_PSTAT: bus_rdata[PSTAT_ACT_BIT]   = pll_active;
      default:  bus_rdata = '0;
    endcase
  end

  a_r2_enable_stored: assert property (
    @(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> en_q == $past(bus_wdata[CTRL_EN_BIT]));

  a_r6_request_from_votes: assert property (
    @(posedge clk) disable iff (!rst_n)
    wr_pvote |=> pll_req_o == (|$past(bus_wdata[NUM_VOTERS-1:0])));

  a_r8_bus_request_stored: assert property (
    @(posedge clk) disable iff (!rst_n)
    wr_bvote |=> bus_branch_req_o == $past(bus_wdata[BVOTE_BIT]));
endmodule

// File: tb/sim_cbg_branch_top.sv
`timescale 1ns/1ps
module sim_cbg_branch_top;
  logic        clk = 1'b0;
  logic        src_clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        gclk_o, pll_req_o, pll_lock_i, bus_branch_req_o;

  int n_chk = 0, n_fail = 0;
  int gedges = 0, glitches = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always #3.5 src_clk = ~src_clk;

  cbg_branch_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_clk(src_clk), .gclk_o(gclk_o), .pll_req_o(pll_req_o),
    .pll_lock_i(pll_lock_i), .bus_branch_req_o(bus_branch_req_o));

  always @(posedge gclk_o) gedges++;
  // R4: gated clock must be low shortly after each source fall
  always @(negedge src_clk) begin
    #0.2;
    if (gclk_o) glitches++;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // table: address, write data, expected read, expected pll_req, expected bus req
  localparam int NV = 8;
  localparam logic [1:0]  T_A[NV]  = '{2'd0, 2'd1, 2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd2};
  localparam logic [31:0] T_W[NV]  = '{32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'h0000_0008, 32'h0,
                                       32'hFFFF_FFFF, 32'hFFFF_FBFF, 32'hFFFF_FFFF, 32'h0000_0400};
  localparam logic [31:0] T_E[NV]  = '{32'h8000_0000, 32'h0000_000F, 32'h0000_0008, 32'h0,
                                       32'h0000_0400, 32'h0, 32'h0, 32'h0000_0400};
  localparam logic        T_PR[NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic        T_BR[NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam string       T_R[NV]  = '{"R2", "R6", "R6", "R6", "R8", "R8", "R9", "R8"};

  initial begin
    logic [31:0] v;
    int first_off0, edges_at_off0;
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; pll_lock_i = 0;
    cycles(4);
    @(negedge clk) rst_n = 1;
    cycles(4);

    // R1 reset state
    rd(2'd0, v); check(v == 32'h8000_0000, "R1 ctrl", v, 32'h8000_0000);
    rd(2'd1, v); check(v == 0, "R1 pvote", v, 0);
    rd(2'd2, v); check(v == 0, "R1 bvote", v, 0);
    rd(2'd3, v); check(v == 0, "R1 pstat", v, 0);
    check({gclk_o, pll_req_o, bus_branch_req_o} == 0, "R1 pins",
          {29'b0, gclk_o, pll_req_o, bus_branch_req_o}, 0);

    // register table
    for (int i = 0; i < NV; i++) begin
      wr(T_A[i], T_W[i]);
      rd(T_A[i], v);
      check(v == T_E[i], T_R[i], v, T_E[i]);
      check(pll_req_o == T_PR[i] && bus_branch_req_o == T_BR[i], T_R[i],
            {30'b0, pll_req_o, bus_branch_req_o}, {30'b0, T_PR[i], T_BR[i]});
    end

    // R3/R4 enable and poll the off flag
    cycles(2);
    gedges = 0;
    wr(2'd0, 32'h1);
    rd(2'd0, v); check(v == 32'h8000_0001, "R3 off still set", v, 32'h8000_0001);
    first_off0 = -1; edges_at_off0 = 0;
    for (int i = 0; i < 40 && first_off0 < 0; i++) begin
      rd(2'd0, v);
      if (!v[31]) begin first_off0 = i; edges_at_off0 = gedges; end
      @(negedge clk);
    end
    check(first_off0 >= 0, "R3 off cleared", first_off0, 0);
    check(edges_at_off0 > 0, "R3 edges before clear", edges_at_off0, 1);
    cycles(20);
    check(gedges > 5, "R4 gated clock toggles", gedges, 6);

    // R5 disable
    wr(2'd0, 32'h0);
    cycles(20);
    rd(2'd0, v); check(v == 32'h8000_0000, "R5 off set again", v, 32'h8000_0000);
    gedges = 0;
    cycles(20);
    check(gedges == 0, "R5 no edges after stop", gedges, 0);
    check(gclk_o == 0, "R5 parked low", gclk_o, 0);
    check(glitches == 0, "R4 high while source low", glitches, 0);

    // R7 lock without vote
    pll_lock_i = 1;
    cycles(30);
    rd(2'd3, v); check(v == 0, "R7 no vote no active", v, 0);
    pll_lock_i = 0;
    cycles(4);

    // R7 qualified lock
    wr(2'd1, 32'h1);
    @(negedge clk) pll_lock_i = 1;
    cycles(10);
    rd(2'd3, v); check(v == 0, "R7 not yet active", v, 0);
    cycles(12);
    rd(2'd3, v); check(v == 32'h0002_0000, "R7 active", v, 32'h0002_0000);
    // R9 write to status ignored
    wr(2'd3, 32'h0);
    rd(2'd3, v); check(v == 32'h0002_0000, "R9 status read-only", v, 32'h0002_0000);
    @(negedge clk) pll_lock_i = 0;
    cycles(4);
    rd(2'd3, v); check(v == 0, "R7 drops with lock", v, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule